// File: doc/BRIEF.md
# Readout Source to Queue Router

This block sits between a detector readout front end and the packet builders for the bulk data links. Each incoming readout word names its origin with three identifiers: a ring, a front-end, and a channel inside one of the front-end's two 64-channel halves. The block joins the two halves into a single 128-channel number. It then uses the front-end and an 8-channel group of that number to index a mapping table. The table returns a bitmask of output queues. A channel that lies in an overlap region has several bits set in its mask, and its word is copied to every one of those queues.

The input is a valid/ready stream. A word transfers on a clock edge where `in_valid` and `in_ready` are both high. While `in_valid` is high, the source must hold the word stable. The output side presents one forwarded word, with a per-queue enable mask `q_en`:

- A queue takes the word in a cycle where its `q_en` bit is high. There is no second handshake on that side.
- `q_en` goes nonzero only in a cycle where every queue in the word's mask shows `q_ready`. A word is therefore delivered to all of its queues together or to none of them.
- `q_ready` must not depend combinationally on `q_en`.

Mapping entries are loaded through a plain write port, one 8-bit mask per entry. A word whose mask is empty is discarded and counted.

Top module: `rsq_router`

## Requirements
- R1: The forwarded channel is the 7-bit value `{in_half, in_chan}`, so half 1 adds 64 to the channel number.
- R2: The forwarded ring, front-end and data fields equal the values presented when the word was accepted.
- R3: The mapping table address is `{fee[3:0], group[3:0]}`, where group is bits 6..3 of the merged channel. The mask written to that address (bit q selects queue q) is the set of queues that receive the word.
- R4: A word mapped to several queues raises all of their `q_en` bits in the same cycle.
- R5: No `q_en` bit rises while any queue in the held word's mask has `q_ready` low. During such a stall the held word stays unchanged and `in_ready` is low.
- R6: A word accepted while its table entry is zero produces no `q_en`, and `drop_count` rises by one on the next cycle.
- R7: A table write changes only words accepted after the write's clock edge. A word already held keeps the mask it was accepted with.
- R8: After reset, `in_ready` is 1, `q_en` is 0, `drop_count` is 0 and every table entry is 0.
- R9: A word accepted at a clock edge is offered on the output right after that edge. With every queue ready, one word is accepted per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Readout word valid |
| in_ready | output | 1 | Router can take a word |
| in_ring | input | 4 | Ring identifier |
| in_fee | input | 4 | Front-end identifier |
| in_half | input | 1 | Front-end half (0 = channels 0..63, 1 = 64..127) |
| in_chan | input | 6 | Channel within the half |
| in_data | input | 32 | Readout payload |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | 8 | Table address {fee, group} |
| cfg_wdata | input | 8 | Queue mask to store |
| q_ready | input | 8 | Per-queue readiness |
| q_en | output | 8 | Per-queue take-this-word enables |
| out_ring | output | 4 | Forwarded ring identifier |
| out_fee | output | 4 | Forwarded front-end identifier |
| out_chan | output | 7 | Forwarded merged channel |
| out_data | output | 32 | Forwarded payload |
| drop_count | output | 16 | Count of words discarded for an empty mask |

## Verification
A corrupted table entry or a wrong group slice sends a word to the wrong queue set. That shows up in the first `q_en` pulse after acceptance, one cycle later. A broken unwrap shows as an `out_chan` that is off by 64 or lands in the wrong group. A faulty all-or-nothing gate would raise some enables during a stall, at the very first cycle a selected queue is not ready. A mask snapshot taken too late would deliver a held word with a mask written during its stall, which is visible when the stall ends.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  localparam int RING_W    = 4;
  localparam int FEE_W     = 4;
  localparam int HALF_CH_W = 6;
  localparam int GRP_W     = 4;
  localparam int DATA_W    = 32;
  localparam int NQ        = 8;

  localparam int CHAN_W = HALF_CH_W + 1;
  localparam int ADDR_W = FEE_W + GRP_W;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef logic [NQ-1:0] qmask_t;

  typedef struct packed {
    logic [RING_W-1:0] ring;
    logic [FEE_W-1:0]  fee;
    logic [CHAN_W-1:0] chan;
    logic [DATA_W-1:0] data;
  } rdo_word_t;
endpackage

// File: rtl/rsq_unwrap.sv
module rsq_unwrap
  import rsq_pkg::*;
(
  input  logic [RING_W-1:0]    ring,
  input  logic [FEE_W-1:0]     fee,
  input  logic                 half,
  input  logic [HALF_CH_W-1:0] chan,
  input  logic [DATA_W-1:0]    data,
  output rdo_word_t            word,
  output logic [ADDR_W-1:0]    tbl_addr
);
  logic [CHAN_W-1:0] merged;

  always_comb begin
    merged    = {half, chan};
    word.ring = ring;
    word.fee  = fee;
    word.chan = merged;
    word.data = data;
    tbl_addr  = {fee, merged[CHAN_W-1 -: GRP_W]};
  end
endmodule

// File: rtl/rsq_map_table.sv
module rsq_map_table
  import rsq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  qmask_t            wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output qmask_t            rd_mask
);
  qmask_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_mask = mem[rd_addr];

  AST_TABLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mem[$past(wr_addr)] == $past(wr_data))); // R3
endmodule

// File: rtl/rsq_fanout.sv
module rsq_fanout
  import rsq_pkg::*;
#(
  parameter int DROP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  rdo_word_t         in_word,
  input  qmask_t            in_mask,
  output logic              in_ready,
  input  qmask_t            q_ready,
  output qmask_t            q_en,
  output rdo_word_t         out_word,
  output logic [DROP_W-1:0] drop_count
);
  logic              hold_v;
  rdo_word_t         hold_word;
  qmask_t            hold_mask;
  logic [DROP_W-1:0] drop_q;
  logic              all_ok;
  logic              fire;
  logic              accept;

  always_comb begin
    all_ok   = ((hold_mask & ~q_ready) == '0);
    fire     = hold_v && all_ok;
    in_ready = !hold_v || fire;
    accept   = in_valid && in_ready;
    q_en     = fire ? hold_mask : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v    <= 1'b0;
      hold_word <= '0;
      hold_mask <= '0;
      drop_q    <= '0;
    end else begin
      if (accept && (in_mask != '0)) begin
        hold_v    <= 1'b1;
        hold_word <= in_word;
        hold_mask <= in_mask;
      end else if (fire) begin
        hold_v <= 1'b0;
      end
      if (accept && (in_mask == '0)) drop_q <= drop_q + 1'b1;
    end
  end

  assign out_word   = hold_word;
  assign drop_count = drop_q;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_v && !fire) |=> (hold_v && $stable(hold_word) && $stable(hold_mask))); // R5
endmodule

// File: rtl/rsq_router.sv
module rsq_router
  import rsq_pkg::*;
#(
  parameter int DROP_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [RING_W-1:0]    in_ring,
  input  logic [FEE_W-1:0]     in_fee,
  input  logic                 in_half,
  input  logic [HALF_CH_W-1:0] in_chan,
  input  logic [DATA_W-1:0]    in_data,
  input  logic                 cfg_we,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [NQ-1:0]        cfg_wdata,
  input  logic [NQ-1:0]        q_ready,
  output logic [NQ-1:0]        q_en,
  output logic [RING_W-1:0]    out_ring,
  output logic [FEE_W-1:0]     out_fee,
  output logic [CHAN_W-1:0]    out_chan,
  output logic [DATA_W-1:0]    out_data,
  output logic [DROP_W-1:0]    drop_count
);
  rdo_word_t         in_word;
  rdo_word_t         out_word;
  logic [ADDR_W-1:0] lookup_addr;
  qmask_t            tbl_mask;

  rsq_unwrap u_unwrap (
    .ring     (in_ring),
    .fee      (in_fee),
    .half     (in_half),
    .chan     (in_chan),
    .data     (in_data),
    .word     (in_word),
    .tbl_addr (lookup_addr)
  );

  rsq_map_table u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_addr (cfg_addr),
    .wr_data (cfg_wdata),
    .rd_addr (lookup_addr),
    .rd_mask (tbl_mask)
  );

  rsq_fanout #(.DROP_W(DROP_W)) u_fanout (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_word    (in_word),
    .in_mask    (tbl_mask),
    .in_ready   (in_ready),
    .q_ready    (q_ready),
    .q_en       (q_en),
    .out_word   (out_word),
    .drop_count (drop_count)
  );

  assign out_ring = out_word.ring;
  assign out_fee  = out_word.fee;
  assign out_chan = out_word.chan;
  assign out_data = out_word.data;

  AST_EN_WITHIN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ((q_en & ~q_ready) == '0)); // R5
  AST_CHAN_MERGED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (tbl_mask != '0)) |=> (out_chan == $past({in_half, in_chan}))); // R1
  AST_DROP_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (tbl_mask == '0)) |=>
      (drop_count == DROP_W'($past(drop_count) + 1'b1))); // R6
  AST_DROP_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (tbl_mask == '0) && (q_en == '0)) |=> (q_en == '0)); // R6
endmodule

// File: tb/rsq_router_tb.sv
module rsq_router_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0]  mask;
    logic [3:0]  ring;
    logic [3:0]  fee;
    logic [6:0]  chan;
    logic [31:0] data;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_ring = '0;
  logic [3:0]  in_fee = '0;
  logic        in_half = 1'b0;
  logic [5:0]  in_chan = '0;
  logic [31:0] in_data = '0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  q_ready = '0;
  logic [7:0]  q_en;
  logic [3:0]  out_ring;
  logic [3:0]  out_fee;
  logic [6:0]  out_chan;
  logic [31:0] out_data;
  logic [15:0] drop_count;

  int checks = 0;
  int fails = 0;
  int exp_drops = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic [7:0] model [256];
  exp_t sb[$];

  rsq_router dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_ring(in_ring), .in_fee(in_fee), .in_half(in_half), .in_chan(in_chan),
    .in_data(in_data), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .q_ready(q_ready), .q_en(q_en), .out_ring(out_ring), .out_fee(out_fee),
    .out_chan(out_chan), .out_data(out_data), .drop_count(drop_count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [3:0] fee, input logic [3:0] grp, input logic [7:0] m);
    cfg_we = 1'b1; cfg_addr = {fee, grp}; cfg_wdata = m;
    @(posedge clk); #1;
    model[{fee, grp}] = m;
    cfg_we = 1'b0;
  endtask

  task automatic send(input logic [3:0] ring, input logic [3:0] fee, input logic half,
                      input logic [5:0] ch, input logic [31:0] data);
    logic [6:0] u;
    logic [7:0] m;
    exp_t e;
    in_ring = ring; in_fee = fee; in_half = half; in_chan = ch; in_data = data;
    in_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    u = {half, ch};
    m = model[{fee, u[6:3]}];
    if (m != 0) begin
      e.mask = m; e.ring = ring; e.fee = fee; e.chan = u; e.data = data;
      sb.push_back(e);
    end else begin
      exp_drops++;
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  // Monitor: pops expected items as enables appear
  always @(negedge clk) begin
    if (rst_n && (q_en != 0)) begin
      chk((q_en & ~q_ready) == 0, "R5 enables within ready", q_en, q_ready);
      if (sb.size() == 0) begin
        chk(1'b0, "R6 unexpected output", q_en, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(q_en == e.mask, "R3 R4 queue mask", q_en, e.mask);
        chk(out_chan == e.chan, "R1 merged channel", out_chan, e.chan);
        chk({out_ring, out_fee, out_data} == {e.ring, e.fee, e.data}, "R2 fields",
            {out_ring, out_fee, out_data}, {e.ring, e.fee, e.data});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int c0;
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R8 in_ready after reset", in_ready, 1);
    chk(q_en == 0, "R8 q_en after reset", q_en, 0);
    chk(drop_count == 0, "R8 drop_count after reset", drop_count, 0);
    @(posedge clk); #1;

    // Empty table: dropped (R8, R6)
    q_ready = 8'hFF;
    send(4'h1, 4'h2, 1'b0, 6'd5, 32'hDEAD0001);
    @(negedge clk);
    chk(drop_count == 16'(exp_drops), "R6 R8 drop on empty entry", drop_count, exp_drops);
    chk(q_en == 0, "R6 no enable on drop", q_en, 0);
    @(posedge clk); #1;

    // Table load (R3)
    cfg_write(4'h2, 4'd0,  8'h01);
    cfg_write(4'h2, 4'd7,  8'h03);
    cfg_write(4'h2, 4'd8,  8'h0C);
    cfg_write(4'h2, 4'd15, 8'hF0);
    cfg_write(4'h5, 4'd3,  8'h07);

    // Back-to-back group boundaries, throughput (R1, R3, R4, R9)
    c0 = cyc;
    send(4'h1, 4'h2, 1'b0, 6'd5,  32'h00000011);
    send(4'h3, 4'h2, 1'b0, 6'd63, 32'h00000022);
    send(4'h7, 4'h2, 1'b1, 6'd0,  32'h00000033);
    send(4'hA, 4'h2, 1'b1, 6'd63, 32'h00000044);
    send(4'hF, 4'h5, 1'b0, 6'd24, 32'h00000055);
    chk((cyc - c0) == 5, "R9 one word per cycle", cyc - c0, 5);
    repeat (2) @(posedge clk); #1;
    chk(sb.size() == 0, "R9 all delivered", sb.size(), 0);

    // Unmapped front-end drops (R6)
    send(4'h0, 4'h3, 1'b0, 6'd5, 32'h00000066);
    @(negedge clk);
    chk(drop_count == 16'(exp_drops), "R6 second drop", drop_count, exp_drops);
    @(posedge clk); #1;

    // Stall with partial readiness (R5) and a write during the stall (R7)
    q_ready = 8'h01;
    send(4'h4, 4'h2, 1'b0, 6'd60, 32'h00000077);
    cfg_write(4'h2, 4'd7, 8'h80);
    in_ring = 4'h9; in_fee = 4'h2; in_half = 1'b0; in_chan = 6'd1; in_data = 32'h88;
    in_valid = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(q_en == 0, "R5 no partial enable", q_en, 0);
      chk(in_ready == 1'b0, "R5 input stalled", in_ready, 0);
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
    q_ready = 8'hFF;
    repeat (2) @(posedge clk); #1;
    chk(sb.size() == 0, "R7 held word used old mask", sb.size(), 0);

    // New mask for later words (R7)
    send(4'h4, 4'h2, 1'b0, 6'd60, 32'h00000099);
    repeat (2) @(posedge clk); #1;
    chk(sb.size() == 0, "R7 new mask delivered", sb.size(), 0);
    chk(drop_count == 16'(exp_drops), "R6 final drop count", drop_count, exp_drops);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule